// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block produces the count-enable strobe that advances a timer. A 3-bit select input picks the source. It can pick no source at all, which stops the timer. It can pick one tap of a free-running prescaler that divides the system clock by 1, 8, 64, 256 or 1024. It can also pick edges seen on an external input pin, with the edge polarity chosen by the same select code. The output is a one-cycle pulse in the system clock domain. The timer that consumes it increments once for every high cycle.

The pin input carries the pad level itself. The block has no direction input, so edges are counted even while the pin is being driven as an output. Software can therefore advance the timer by toggling that output. The pin goes through a two-flop synchronizer and then an edge detector. The prescaler never stops and is never cleared by a change of select code. A tap therefore keeps its phase relative to reset.

Top module: `timer_clk_sel`

## Requirements
- R1: While rst_ni is low, tick_o is 0. The prescaler count restarts from zero when reset is released, so the first clock edge after release is count 0.
- R2: With select code 3'b000, tick_o stays 0.
- R3: With select code 3'b001, tick_o is 1 after every clock edge.
- R4: Codes 3'b010, 3'b011, 3'b100 and 3'b101 select divide-by 8, 64, 256 and 1024. Take the edges since reset release, counted from 0. tick_o is 1 after an edge exactly when that count, taken modulo the divisor, is zero.
- R5: With code 3'b110, each falling edge of pin_i gives exactly one tick_o pulse. Let p[e] be the pin level sampled at edge e. tick_o after edge e equals !p[e-2] && p[e-3], which is two to three clocks after the pin changes.
- R6: With code 3'b111, each rising edge of pin_i gives exactly one pulse. tick_o after edge e equals p[e-2] && !p[e-3].
- R7: A select code applied before edge e decides tick_o after edge e. Changing the code neither resets nor shifts the prescaler phase. The synchronizer tracks the pin in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Count source select code |
| pin_i | input | 1 | External pad level, asynchronous |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The bench builds the block with its default 10-bit prescaler. With that width, the divide-by-1024 tap and a full wrap of the counter are reached within a few thousand cycles. The bench holds each tap code long enough to see several pulse periods. Random segments switch codes at arbitrary prescaler phases, and a second reset in mid-run shows that the phase restarts. Pin toggles at varied spacing, including toggles made while a prescaler code is selected, exercise the synchronizer latency and the one-pulse-per-edge rule in both polarities.

// File: rtl/timer_clk_pkg.sv
package timer_clk_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'b000,
    SRC_DIV1     = 3'b001,
    SRC_DIV8     = 3'b010,
    SRC_DIV64    = 3'b011,
    SRC_DIV256   = 3'b100,
    SRC_DIV1024  = 3'b101,
    SRC_PIN_FALL = 3'b110,
    SRC_PIN_RISE = 3'b111
  } src_sel_e;

  localparam int unsigned NUM_TAPS = 4;

  // log2 of each divided tap, in select-code order
  function automatic int unsigned tap_shift(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/timer_clk_prescaler.sv
module timer_clk_prescaler
  import timer_clk_pkg::*;
#(
  parameter int unsigned PRESC_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned SH = (tap_shift(g) > PRESC_W) ? PRESC_W : tap_shift(g);
    assign tap_o[g] = (cnt_q[SH-1:0] == '0);
  end

endmodule

// File: rtl/timer_clk_pin_edge.sv
module timer_clk_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;

endmodule

// File: rtl/timer_clk_src_mux.sv
module timer_clk_src_mux
  import timer_clk_pkg::*;
(
  input  logic [2:0]          sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                en_o
);

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_OFF:      en_o = 1'b0;
      SRC_DIV1:     en_o = 1'b1;
      SRC_DIV8:     en_o = tap_i[0];
      SRC_DIV64:    en_o = tap_i[1];
      SRC_DIV256:   en_o = tap_i[2];
      SRC_DIV1024:  en_o = tap_i[3];
      SRC_PIN_FALL: en_o = fall_i;
      SRC_PIN_RISE: en_o = rise_i;
      default:      en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel
  import timer_clk_pkg::*;
#(
  parameter int unsigned PRESC_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       pin_i,
  output logic       tick_o
);

  logic [NUM_TAPS-1:0] tap;
  logic                rise, fall, en_d, tick_q;

  timer_clk_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap)
  );

  timer_clk_pin_edge #(.SYNC_STAGES(2)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  timer_clk_src_mux u_mux (
    .sel_i  (sel_i),
    .tap_i  (tap),
    .rise_i (rise),
    .fall_i (fall),
    .en_o   (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= en_d;
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/timer_clk_sel_chk.sv
module timer_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       pin_i,
  input logic       tick_o
);

  logic [9:0] cyc_q;   // edges since reset, wraps like a 10-bit prescaler
  logic [1:0] warm_q;  // saturates at 3

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      warm_q <= '0;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
      if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
    end
  end

  always @(negedge clk_i) if (!rst_ni) a_r1_reset_quiet: assert (tick_o == 1'b0);

  a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b000) |=> !tick_o);

  a_r3_div1_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001) |=> tick_o);

  a_r4_div8_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b010) |=> (tick_o == ($past(cyc_q[2:0]) == 3'd0)));

  a_r4_div64_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b011) |=> (tick_o == ($past(cyc_q[5:0]) == 6'd0)));

  a_r4_div256_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b100) |=> (tick_o == ($past(cyc_q[7:0]) == 8'd0)));

  a_r4_div1024_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b101) |=> (tick_o == ($past(cyc_q) == 10'd0)));

  a_r5_fall_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b110 && warm_q == 2'd3) |=>
      (tick_o == (!$past(pin_i, 3) && $past(pin_i, 4))));

  a_r6_rise_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b111 && warm_q == 2'd3) |=>
      (tick_o == ($past(pin_i, 3) && !$past(pin_i, 4))));

endmodule

bind timer_clk_sel timer_clk_sel_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .pin_i  (pin_i),
  .tick_o (tick_o)
);

// File: tb/timer_clk_sel_tb_top.sv
module timer_clk_sel_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'b000;
  logic       pin_i = 1'b0;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0] mcnt = '0;
  logic       h0 = 0, h1 = 0, h2 = 0;
  logic [2:0] last_sel = 3'b000;

  always #2.5 clk_i = ~clk_i;

  timer_clk_sel dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .pin_i  (pin_i),
    .tick_o (tick_o)
  );

  function automatic logic expect_tick(input logic [2:0] s);
    case (s)
      3'b000:  return 1'b0;
      3'b001:  return 1'b1;
      3'b010:  return mcnt[2:0] == 0;
      3'b011:  return mcnt[5:0] == 0;
      3'b100:  return mcnt[7:0] == 0;
      3'b101:  return mcnt == 0;
      3'b110:  return !h1 && h2;
      default: return h1 && !h2;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s, input bit changed);
    if (changed) return "R7";
    case (s)
      3'b000:  return "R2";
      3'b001:  return "R3";
      3'b110:  return "R5";
      3'b111:  return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t tick_o=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // inputs driven at negedge, result sampled at the next negedge
  task automatic step(input logic [2:0] s, input logic p);
    logic e;
    string r;
    sel_i = s;
    pin_i = p;
    e = expect_tick(s);
    r = req_of(s, s != last_sel);
    @(posedge clk_i);
    mcnt++;
    h2 = h1; h1 = h0; h0 = p;
    last_sel = s;
    @(negedge clk_i);
    check(r, tick_o, e);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", tick_o, 1'b0);
    mcnt = '0; h0 = 0; h1 = 0; h2 = 0;
    rst_ni = 1'b1;
  endtask

  task automatic hold(input logic [2:0] s, input int n);
    for (int i = 0; i < n; i++) step(s, pin_i);
  endtask

  task automatic toggles(input logic [2:0] s, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(s, ~pin_i);
      for (int j = 0; j < gap; j++) step(s, pin_i);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk_i);
    do_reset();
    // directed: each source
    hold(3'b000, 40);
    hold(3'b001, 20);
    hold(3'b010, 40);
    hold(3'b011, 200);
    hold(3'b100, 600);
    hold(3'b101, 2200);
    toggles(3'b111, 30, 4);
    toggles(3'b110, 30, 4);
    toggles(3'b111, 20, 0);    // toggle every cycle
    toggles(3'b110, 20, 1);
    toggles(3'b111, 20, 2);
    // edges made while a divider is selected, then switch to pin mode
    toggles(3'b010, 3, 2);
    toggles(3'b111, 5, 3);
    // mid-run reset restarts prescaler phase
    hold(3'b011, 37);
    @(negedge clk_i);
    do_reset();
    hold(3'b010, 30);
    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      logic [2:0] s;
      int len;
      s = 3'($urandom_range(0, 7));
      len = $urandom_range(1, 300);
      for (int i = 0; i < len; i++)
        step(s, ($urandom_range(0, 3) == 0) ? ~pin_i : pin_i);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule